// File: doc/BRIEF.md
# Dual-Clock Memory Fill and Wrapped Descending Scan

This block owns a two-port memory with one write clock and one read clock. After reset, a write sequencer fills every word once with a value computed from its address. A flag marks the end of the fill. That flag crosses into the read clock domain, and a read sequencer then walks the memory once in descending address order.

In rotate mode, the walk begins at a chosen start address, passes through address 0, wraps to the top word and comes back down to the start word, which is read a second time. In descend mode, the stored value equals the address and the walk covers every word from the top down to 0. Each word read is streamed out with its address and a valid strobe. The block also keeps the largest value seen and the address it came from, and marks them valid when the pass ends.

The write side is meant for a clock five times faster than the read side. The two clocks are independent.

Top module: `dcram_rotate_scan`

## Requirements
- R1: In rotate mode, word a is written with ((a + OFFSET) mod DEPTH), truncated to its low DATA_W bits. With the defaults, word 0 holds 2, word 1022 holds 0 and word 1023 holds 1. In descend mode, word a holds a.
- R2: `fill_done` is low until the DEPTH-th rising write-clock edge after `wr_rst` is released. It goes high at that edge and then stays high until reset.
- R3: `fill_done` reaches the read domain through a two-flop synchronizer. `rd_valid` is never high while `fill_done` is low.
- R4: In rotate mode, the addresses read are START_ADDR, START_ADDR-1, down to 0, then DEPTH-1 down to START_ADDR. That is DEPTH+1 reads, and START_ADDR is read at both ends.
- R5: In descend mode, the addresses read are DEPTH-1 down to 0, which is DEPTH reads.
- R6: `rd_data` and `rd_addr` are aligned. On every cycle where `rd_valid` is high, `rd_data` equals the word stored at `rd_addr`.
- R7: `max_data` is the largest value in the pass, compared over the full DATA_W bits with strict greater-than. On a tie, `max_addr` keeps the first address read.
- R8: `max_valid` rises one read-clock cycle after the last `rd_valid` beat. While `max_valid` is high, `max_data` and `max_addr` hold steady.
- R9: Only one pass runs. After the last beat, `rd_valid` stays low until reset.
- R10: Resets are synchronous and active-high. `wr_rst` clears the write sequencer and `fill_done`. `rd_rst` clears `rd_valid`, `max_valid`, `max_data` and `max_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| fill_done | output | 1 | Sticky flag: every word has been written (write domain) |
| rd_valid | output | 1 | A read beat is on `rd_addr`/`rd_data` |
| rd_addr | output | ADDR_W | Address of the current read beat |
| rd_data | output | DATA_W | Word read from `rd_addr` |
| max_valid | output | 1 | The pass is complete and the maximum is final |
| max_addr | output | ADDR_W | Address where the maximum was first seen |
| max_data | output | DATA_W | Largest value read |

## Verification
The bench builds three copies of the block, and each one targets a different behaviour:
- The first uses the default rotate build: 1024 words of 16 bits, start address 700, offset 2. It covers the wrap from 0 to 1023, the second read of word 700, and the exact edge at which `fill_done` rises.
- The second runs in descend mode, which covers the identity pattern and the full top-to-bottom walk.
- The third narrows the data to 8 bits. The largest value then repeats at four addresses, so the first-seen tie rule for `max_addr` can be observed at the ports.

// File: rtl/ramrot_pkg.sv
package ramrot_pkg;

    typedef enum logic {
        SCAN_ROTATE  = 1'b0,
        SCAN_DESCEND = 1'b1
    } scan_mode_e;

    typedef enum logic {
        FL_RUN  = 1'b0,
        FL_DONE = 1'b1
    } fill_state_e;

    typedef enum logic [1:0] {
        RS_WAIT = 2'd0,
        RS_RUN  = 2'd1,
        RS_DONE = 2'd2
    } read_state_e;

    // Value stored at address a: address plus offset, wrapped at depth.
    function automatic int unsigned fill_value(int unsigned a, int unsigned off,
                                               int unsigned depth);
        return (a + off) % depth;
    endfunction

endpackage

// File: rtl/ramrot_fill.sv
module ramrot_fill #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned OFFSET = 2,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fill_done
);
    import ramrot_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    fill_state_e state;

    assign wr_en   = (state == FL_RUN);
    assign wr_data = DATA_W'(fill_value(32'(wr_addr), OFFSET, DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FL_RUN;
            wr_addr   <= '0;
            fill_done <= 1'b0;
        end else if (state == FL_RUN) begin
            if (wr_addr == LAST_ADDR) begin
                state     <= FL_DONE;
                fill_done <= 1'b1;
            end else begin
                wr_addr <= wr_addr + 1'b1;
            end
        end
    end

    // R2: the flag only rises right after the top word was written
    p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_done) |-> ($past(wr_en) && ($past(wr_addr) == LAST_ADDR)));

    // R2: the flag is sticky
    p_done_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> fill_done);

    // R1: no write after the fill has completed
    p_no_write_after_r1: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> !wr_en);

endmodule

// File: rtl/ramrot_sync.sv
module ramrot_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ramrot_mem.sv
module ramrot_mem #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= store[raddr];
    end

endmodule

// File: rtl/ramrot_reader.sv
module ramrot_reader #(
    parameter int unsigned           DEPTH      = 1024,
    parameter int unsigned           START_ADDR = 700,
    parameter ramrot_pkg::scan_mode_e MODE      = ramrot_pkg::SCAN_ROTATE,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              beat_valid,
    output logic              beat_last,
    output logic [ADDR_W-1:0] beat_addr
);
    import ramrot_pkg::*;

    localparam int unsigned NUM_READS = (MODE == SCAN_ROTATE) ? DEPTH + 1 : DEPTH;
    localparam int unsigned FIRST     = (MODE == SCAN_ROTATE) ? START_ADDR : DEPTH - 1;
    localparam int unsigned CNT_W     = $clog2(NUM_READS + 1);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [ADDR_W-1:0] addr;
    } beat_t;

    read_state_e      state;
    logic [CNT_W-1:0] issued;
    logic             is_last;
    beat_t            beat_q;

    assign rd_en   = (state == RS_RUN);
    assign is_last = (issued == CNT_W'(NUM_READS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_WAIT;
            rd_addr <= '0;
            issued  <= '0;
        end else begin
            case (state)
                RS_WAIT: if (go) begin
                    state   <= RS_RUN;
                    rd_addr <= ADDR_W'(FIRST);
                    issued  <= '0;
                end
                RS_RUN: begin
                    rd_addr <= (rd_addr == '0) ? TOP : rd_addr - 1'b1;
                    issued  <= issued + 1'b1;
                    if (is_last) state <= RS_DONE;
                end
                default: state <= RS_DONE;
            endcase
        end
    end

    // Beat registered alongside the memory's output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= rd_en;
            beat_q.last  <= rd_en && is_last;
            beat_q.addr  <= rd_addr;
        end
    end

    assign beat_valid = beat_q.valid;
    assign beat_last  = beat_q.last;
    assign beat_addr  = beat_q.addr;

    // R3: reading only while the synchronized fill flag is high
    p_no_early_read_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> go);

    // R4: consecutive reads step down by one, wrapping at zero
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |->
        (rd_addr == (($past(rd_addr) == '0) ? TOP : $past(rd_addr) - 1'b1)));

    // R9: no read after the pass has finished
    p_single_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (state == RS_DONE) |=> !rd_en);

endmodule

// File: rtl/ramrot_peak.sv
module ramrot_peak #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              max_valid,
    output logic [DATA_W-1:0] max_data,
    output logic [ADDR_W-1:0] max_addr
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen      <= 1'b0;
            max_valid <= 1'b0;
            max_data  <= '0;
            max_addr  <= '0;
        end else if (in_valid) begin
            seen <= 1'b1;
            if (!seen || (in_data > max_data)) begin
                max_data <= in_data;
                max_addr <= in_addr;
            end
            if (in_last) max_valid <= 1'b1;
        end
    end

    // R7: the running maximum never decreases within a pass
    p_max_rises_r7: assert property (@(posedge clk) disable iff (rst)
        $past(seen) |-> (max_data >= $past(max_data)));

    // R8: final result holds once flagged
    p_max_hold_r8: assert property (@(posedge clk) disable iff (rst)
        max_valid |=> ($stable(max_data) && $stable(max_addr) && max_valid));

endmodule

// File: rtl/dcram_rotate_scan.sv
module dcram_rotate_scan #(
    parameter int unsigned            DEPTH      = 1024,
    parameter int unsigned            DATA_W     = 16,
    parameter int unsigned            OFFSET     = 2,
    parameter int unsigned            START_ADDR = 700,
    parameter ramrot_pkg::scan_mode_e MODE       = ramrot_pkg::SCAN_ROTATE,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic              fill_done,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              max_valid,
    output logic [ADDR_W-1:0] max_addr,
    output logic [DATA_W-1:0] max_data
);
    import ramrot_pkg::*;

    localparam int unsigned EFF_OFFSET = (MODE == SCAN_ROTATE) ? OFFSET : 0;

    logic              w_en;
    logic [ADDR_W-1:0] w_addr;
    logic [DATA_W-1:0] w_data;
    logic              go_sync;
    logic              r_en;
    logic [ADDR_W-1:0] r_addr;
    logic              beat_last;

    ramrot_fill #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFFSET(EFF_OFFSET)) u_fill (
        .clk(wr_clk), .rst(wr_rst), .wr_en(w_en), .wr_addr(w_addr),
        .wr_data(w_data), .fill_done(fill_done)
    );

    ramrot_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .wclk(wr_clk), .we(w_en), .waddr(w_addr), .wdata(w_data),
        .rclk(rd_clk), .re(r_en), .raddr(r_addr), .rdata(rd_data)
    );

    ramrot_sync #(.STAGES(2)) u_sync (
        .clk(rd_clk), .rst(rd_rst), .d_async(fill_done), .q(go_sync)
    );

    ramrot_reader #(.DEPTH(DEPTH), .START_ADDR(START_ADDR), .MODE(MODE)) u_reader (
        .clk(rd_clk), .rst(rd_rst), .go(go_sync), .rd_en(r_en), .rd_addr(r_addr),
        .beat_valid(rd_valid), .beat_last(beat_last), .beat_addr(rd_addr)
    );

    ramrot_peak #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_peak (
        .clk(rd_clk), .rst(rd_rst), .in_valid(rd_valid), .in_last(beat_last),
        .in_data(rd_data), .in_addr(rd_addr), .max_valid(max_valid),
        .max_data(max_data), .max_addr(max_addr)
    );

endmodule

// File: tb/dcram_rotate_scan_test.sv
module dcram_rotate_scan_test;

    localparam int DEPTH = 1024;
    localparam int START = 700;
    localparam int OFF   = 2;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic wr_rst = 1'b1;
    logic rd_rst = 1'b1;

    always #10 wr_clk = ~wr_clk;   // 50 MHz
    always #50 rd_clk = ~rd_clk;   // five times slower

    int checks = 0;
    int bad    = 0;
    bit finished = 1'b0;

    // rotate instance
    logic        a_done, a_valid, a_mvalid;
    logic [9:0]  a_addr, a_maddr;
    logic [15:0] a_data, a_mdata;
    // descend instance
    logic        d_done, d_valid, d_mvalid;
    logic [9:0]  d_addr, d_maddr;
    logic [15:0] d_data, d_mdata;
    // narrow-data rotate instance
    logic        n_done, n_valid, n_mvalid;
    logic [9:0]  n_addr, n_maddr;
    logic [7:0]  n_data, n_mdata;

    dcram_rotate_scan uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .fill_done(a_done), .rd_valid(a_valid), .rd_addr(a_addr), .rd_data(a_data),
        .max_valid(a_mvalid), .max_addr(a_maddr), .max_data(a_mdata)
    );

    dcram_rotate_scan #(.MODE(ramrot_pkg::SCAN_DESCEND)) uut_desc (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .fill_done(d_done), .rd_valid(d_valid), .rd_addr(d_addr), .rd_data(d_data),
        .max_valid(d_mvalid), .max_addr(d_maddr), .max_data(d_mdata)
    );

    dcram_rotate_scan #(.DATA_W(8)) uut_narrow (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .fill_done(n_done), .rd_valid(n_valid), .rd_addr(n_addr), .rd_data(n_data),
        .max_valid(n_mvalid), .max_addr(n_maddr), .max_data(n_mdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R10: outputs cleared while both resets are held
    task automatic t_reset_state();
        repeat (3) @(posedge rd_clk);
        @(negedge rd_clk);
        check(a_done == 1'b0, "R10", "fill_done in reset", a_done, 0);
        check(a_valid == 1'b0, "R10", "rd_valid in reset", a_valid, 0);
        check(a_mvalid == 1'b0, "R10", "max_valid in reset", a_mvalid, 0);
        check(a_mdata == 16'd0, "R10", "max_data in reset", a_mdata, 0);
        check(a_maddr == 10'd0, "R10", "max_addr in reset", a_maddr, 0);
    endtask

    // R2: flag rises exactly at the DEPTH-th write edge
    task automatic t_fill_timing();
        for (int n = 1; n <= DEPTH + 4; n++) begin
            @(posedge wr_clk);
            @(negedge wr_clk);
            if (n == DEPTH - 1)
                check(a_done == 1'b0, "R2", "fill_done one edge early", a_done, 0);
            if (n == DEPTH)
                check(a_done == 1'b1, "R2", "fill_done at last write", a_done, 1);
            if (n == DEPTH + 4)
                check(a_done == 1'b1, "R2", "fill_done sticky", a_done, 1);
        end
    endtask

    // R1 R3 R4 R6: rotated stream, order and contents
    task automatic t_rotate_stream();
        int idx = 0;
        int early = 0;
        while (!a_mvalid) begin
            @(negedge rd_clk);
            if (a_valid && !a_done) early++;
            if (a_valid) begin
                int ea = (START - idx + DEPTH) % DEPTH;
                int ed = (ea + OFF) % DEPTH;
                check(a_addr == 10'(ea), "R4", "rotate address", a_addr, ea);
                check(a_data == 16'(ed), "R6", "rotate data vs address", a_data, ed);
                idx++;
            end
        end
        check(early == 0, "R3", "beats before fill_done", early, 0);
        check(idx == DEPTH + 1, "R4", "rotate read count", idx, DEPTH + 1);
    endtask

    // R1 R5: descend stream
    task automatic t_descend_stream();
        int idx = 0;
        while (!d_mvalid) begin
            @(negedge rd_clk);
            if (d_valid) begin
                int ea = DEPTH - 1 - idx;
                check(d_addr == 10'(ea), "R5", "descend address", d_addr, ea);
                check(d_data == 16'(ea), "R1", "descend data equals address", d_data, ea);
                idx++;
            end
        end
        check(idx == DEPTH, "R5", "descend read count", idx, DEPTH);
    endtask

    // R7 R8: maxima, including the tie case on narrow data
    task automatic t_peaks();
        int best = -1;
        int best_a = 0;
        for (int i = 0; i <= DEPTH; i++) begin
            int a = (START - i + DEPTH) % DEPTH;
            int v = ((a + OFF) % DEPTH) % 256;
            if (v > best) begin
                best = v;
                best_a = a;
            end
        end
        check(a_mvalid == 1'b1, "R8", "rotate max_valid", a_mvalid, 1);
        check(a_mdata == 16'd1023, "R7", "rotate max value", a_mdata, 1023);
        check(a_maddr == 10'd1021, "R7", "rotate max address", a_maddr, 1021);
        check(d_mdata == 16'd1023, "R7", "descend max value", d_mdata, 1023);
        check(d_maddr == 10'd1023, "R7", "descend max address", d_maddr, 1023);
        check(n_mvalid == 1'b1, "R8", "narrow max_valid", n_mvalid, 1);
        check(n_mdata == 8'(best), "R7", "narrow max value", n_mdata, best);
        check(n_maddr == 10'(best_a), "R7", "narrow tie keeps first address", n_maddr, best_a);
    endtask

    // R8 R9: no second pass and results hold
    task automatic t_after_pass();
        int extra = 0;
        int moved = 0;
        logic [15:0] md = a_mdata;
        logic [9:0]  ma = a_maddr;
        repeat (40) begin
            @(negedge rd_clk);
            if (a_valid || d_valid || n_valid) extra++;
            if (a_mdata != md || a_maddr != ma || !a_mvalid) moved++;
        end
        check(extra == 0, "R9", "beats after pass", extra, 0);
        check(moved == 0, "R8", "max changed after valid", moved, 0);
    endtask

    initial begin
        t_reset_state();
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        fork
            t_fill_timing();
            t_rotate_stream();
            t_descend_stream();
        join
        wait (n_mvalid);
        @(negedge rd_clk);
        t_peaks();
        t_after_pass();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule